// File: doc/BRIEF.md
# Hamming Sector ECC Checker and Corrector

This block decides whether a 512-byte sector read back from flash is intact. It takes the raw 32-bit parity accumulator word gathered while the sector was read, rebuilds the 24-bit Hamming code from it and compares that code with the three code bytes kept in the spare area. It then names the outcome as one of four results: clean, one flipped data bit (with its byte and bit position), one flipped bit in the stored code only, or uncorrectable.

The code consists of two 12-bit halves. A single flipped data bit shows up as a difference whose two halves are exact bitwise complements. The rebuilt code is inverted, so a fully erased sector (all ones, accumulator zero) matches erased code bytes (all ones). After a data-bit result, software or a streaming path presents bytes of the sector on the repair port. The byte at the reported index comes back with the bad bit flipped. All other bytes pass through unchanged.

Control is a two-state machine. `ST_IDLE` waits for a start strobe. The start transition moves to `ST_REPORT` and registers the result in the same edge. `ST_REPORT` lasts one cycle and asserts `done`. It returns to `ST_IDLE`, or stays in `ST_REPORT` when another start arrives in that cycle.

Top module: `ham_sector_chk`

## Requirements
- R1: Exactly one cycle after each clock edge with `start` high, `done` is high for one cycle. `status`, `err_byte` and `err_bit` change only at such an edge and hold their values until the next start.
- R2: The rebuilt code is the bitwise inverse of {accumulator bits 27:16, accumulator bits 11:0}, with the latter as bits 11:0. Accumulator bits 31:28 and 15:12 have no effect. The stored code is {`ecc_b2`, `ecc_b1`, `ecc_b0`}, with `ecc_b0` as bits 7:0.
- R3: When the stored and rebuilt codes are equal, `status` is 2'b00 and `err_byte`/`err_bit` are zero. This includes an erased sector with accumulator zero and all code bytes 0xFF.
- R4: Let d be the XOR of the stored and rebuilt codes. When d[11:0] XOR d[23:12] equals 0xFFF and d[23:15] is below SECTOR_BYTES, `status` is 2'b01, `err_byte` is d[23:15] and `err_bit` is d[14:12].
- R5: When the halves are complementary but d[23:15] is not below SECTOR_BYTES, `status` is 2'b11 and the location is zero.
- R6: When d has exactly one bit set, `status` is 2'b10, the location is zero and the repair port changes no byte.
- R7: Any other nonzero d gives `status` 2'b11 with the location zero.
- R8: While `status` is 2'b01, `fix_dout` equals `fix_din` XOR (1 << `err_bit`) when `fix_addr` equals `err_byte`. In every other case `fix_dout` equals `fix_din`.
- R9: After reset `done` is 0, `status` is 2'b00 and the location is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Evaluate the inputs at this edge |
| acc_word | input | 32 | Raw parity accumulator word |
| ecc_b0 | input | 8 | Stored code byte, bits 7:0 |
| ecc_b1 | input | 8 | Stored code byte, bits 15:8 |
| ecc_b2 | input | 8 | Stored code byte, bits 23:16 |
| fix_addr | input | 9 | Index of the byte presented for repair |
| fix_din | input | 8 | Byte presented for repair |
| done | output | 1 | One-cycle result strobe |
| status | output | 2 | 00 clean, 01 data bit fixed, 10 code-only error, 11 uncorrectable |
| err_byte | output | 9 | Byte index of the bad data bit |
| err_bit | output | 3 | Bit index within that byte |
| fix_dout | output | 8 | Repaired byte |

## Verification
The classifier is tested with matching codes from an erased sector and from an arbitrary accumulator word. These show that inversion and half placement are right and that ignored accumulator bits stay ignored. Complementary differences at byte 0, at the last byte and at a mid byte on a second instance with a smaller sector tell a correct location apart from range rejection. Single-bit differences and two-bit differences separate the code-only result from the uncorrectable one. The repair port is probed at the reported byte and at a neighbouring byte, both under a data-fix result and under a code-only result.

// File: rtl/ham_chk_pkg.sv
package ham_chk_pkg;

    typedef enum logic [1:0] {
        RES_CLEAN     = 2'b00,
        RES_DATA_FIX  = 2'b01,
        RES_CODE_ONLY = 2'b10,
        RES_FATAL     = 2'b11
    } ham_res_e;

    typedef enum logic {
        ST_IDLE,
        ST_REPORT
    } ham_state_e;

endpackage

// File: rtl/ham_code_pack.sv
module ham_code_pack #(
    parameter int ACC_W  = 32,
    parameter int HALF_W = 12,
    parameter int HI_LSB = 16
) (
    input  logic [HALF_W-1:0]   acc_lo,
    input  logic [HALF_W-1:0]   acc_hi,
    output logic [2*HALF_W-1:0] code
);
    localparam int CODE_W = 2 * HALF_W;

    // Invert so an erased (all-ones) sector yields a code matching erased bytes.
    always_comb begin
        code = ~{acc_hi, acc_lo};
    end

    initial begin
        if (HI_LSB + HALF_W > ACC_W || HALF_W > HI_LSB || CODE_W < 2)
            $display("ham_code_pack: bad field layout");
    end
endmodule

// File: rtl/ham_diff_classify.sv
module ham_diff_classify
    import ham_chk_pkg::*;
#(
    parameter int HALF_W       = 12,
    parameter int BIT_W        = 3,
    parameter int SECTOR_BYTES = 512
) (
    input  logic [2*HALF_W-1:0]      stored,
    input  logic [2*HALF_W-1:0]      computed,
    output ham_res_e                 res,
    output logic [HALF_W-BIT_W-1:0]  byte_idx,
    output logic [BIT_W-1:0]         bit_idx
);
    localparam int CODE_W = 2 * HALF_W;
    localparam int IDX_W  = HALF_W - BIT_W;
    localparam logic [IDX_W:0]    LIMIT    = SECTOR_BYTES[IDX_W:0];
    localparam logic [HALF_W-1:0] ALL_ONES = {HALF_W{1'b1}};

    logic [CODE_W-1:0] diff;
    logic              halves_comp;
    logic              single_bit;
    logic [IDX_W-1:0]  cand_byte;
    logic [BIT_W-1:0]  cand_bit;
    logic              in_range;

    always_comb begin
        diff        = stored ^ computed;
        halves_comp = (diff[HALF_W-1:0] ^ diff[CODE_W-1:HALF_W]) == ALL_ONES;
        single_bit  = (diff != '0) && ((diff & (diff - 1'b1)) == '0);
        cand_byte   = diff[CODE_W-1:HALF_W+BIT_W];
        cand_bit    = diff[HALF_W+BIT_W-1:HALF_W];
        in_range    = {1'b0, cand_byte} < LIMIT;
    end

    always_comb begin
        res      = RES_FATAL;
        byte_idx = '0;
        bit_idx  = '0;
        if (diff == '0) begin
            res = RES_CLEAN;
        end else if (halves_comp) begin
            if (in_range) begin
                res      = RES_DATA_FIX;
                byte_idx = cand_byte;
                bit_idx  = cand_bit;
            end else begin
                res = RES_FATAL;
            end
        end else if (single_bit) begin
            res = RES_CODE_ONLY;
        end else begin
            res = RES_FATAL;
        end
    end
endmodule

// File: rtl/ham_byte_fixer.sv
module ham_byte_fixer #(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 9
) (
    input  logic                       fix_en,
    input  logic [IDX_W-1:0]           bad_byte,
    input  logic [$clog2(BYTE_W)-1:0]  bad_bit,
    input  logic [IDX_W-1:0]           addr,
    input  logic [BYTE_W-1:0]          din,
    output logic [BYTE_W-1:0]          dout
);
    localparam int BIT_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            if (bad_bit == BIT_W'(i)) mask[i] = 1'b1;
        end
        if (fix_en && (addr == bad_byte)) dout = din ^ mask;
        else                              dout = din;
    end
endmodule

// File: rtl/ham_sector_chk.sv
module ham_sector_chk
    import ham_chk_pkg::*;
#(
    parameter int ACC_W        = 32,
    parameter int HALF_W       = 12,
    parameter int HI_LSB       = 16,
    parameter int BYTE_W       = 8,
    parameter int SECTOR_BYTES = 512,
    localparam int BIT_W       = $clog2(BYTE_W),
    localparam int IDX_W       = HALF_W - BIT_W,
    localparam int CODE_W      = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ACC_W-1:0]  acc_word,
    input  logic [BYTE_W-1:0] ecc_b0,
    input  logic [BYTE_W-1:0] ecc_b1,
    input  logic [BYTE_W-1:0] ecc_b2,
    input  logic [IDX_W-1:0]  fix_addr,
    input  logic [BYTE_W-1:0] fix_din,
    output logic              done,
    output logic [1:0]        status,
    output logic [IDX_W-1:0]  err_byte,
    output logic [BIT_W-1:0]  err_bit,
    output logic [BYTE_W-1:0] fix_dout
);
    ham_state_e        state_q, state_d;
    ham_res_e          res_now, res_q;
    logic [CODE_W-1:0] code_calc;
    logic [CODE_W-1:0] code_kept;
    logic [IDX_W-1:0]  byte_now;
    logic [BIT_W-1:0]  bit_now;

    // Stored code bytes arrive least significant first.
    always_comb code_kept = {ecc_b2, ecc_b1, ecc_b0};

    ham_code_pack #(
        .ACC_W (ACC_W),
        .HALF_W(HALF_W),
        .HI_LSB(HI_LSB)
    ) u_pack (
        .acc_lo(acc_word[HALF_W-1:0]),
        .acc_hi(acc_word[HI_LSB+HALF_W-1:HI_LSB]),
        .code  (code_calc)
    );

    ham_diff_classify #(
        .HALF_W      (HALF_W),
        .BIT_W       (BIT_W),
        .SECTOR_BYTES(SECTOR_BYTES)
    ) u_cls (
        .stored  (code_kept),
        .computed(code_calc),
        .res     (res_now),
        .byte_idx(byte_now),
        .bit_idx (bit_now)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_REPORT;
            ST_REPORT: state_d = start ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result registers, loaded on every start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q    <= RES_CLEAN;
            err_byte <= '0;
            err_bit  <= '0;
        end else if (start) begin
            res_q    <= res_now;
            err_byte <= byte_now;
            err_bit  <= bit_now;
        end
    end

    always_comb begin
        done   = (state_q == ST_REPORT);
        status = res_q;
    end

    ham_byte_fixer #(
        .BYTE_W(BYTE_W),
        .IDX_W (IDX_W)
    ) u_fix (
        .fix_en  (res_q == RES_DATA_FIX),
        .bad_byte(err_byte),
        .bad_bit (err_bit),
        .addr    (fix_addr),
        .din     (fix_din),
        .dout    (fix_dout)
    );
endmodule

// File: rtl/ham_sector_chk_sva.sv
module ham_sector_chk_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [31:0] acc_word,
    input logic [7:0]  ecc_b0,
    input logic [7:0]  ecc_b1,
    input logic [7:0]  ecc_b2,
    input logic [8:0]  fix_addr,
    input logic [7:0]  fix_din,
    input logic        done,
    input logic [1:0]  status,
    input logic [8:0]  err_byte,
    input logic [2:0]  err_bit,
    input logic [7:0]  fix_dout
);
    p_done_follows_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    p_no_spurious_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    p_result_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(status) && $stable(err_byte) && $stable(err_bit)));

    p_match_is_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ({ecc_b2, ecc_b1, ecc_b0} == ~{acc_word[27:16], acc_word[11:0]}))
        |=> (status == 2'b00));

    p_loc_zero_unless_fix_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'b01) |-> (err_byte == 9'd0 && err_bit == 3'd0));

    p_passthrough_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((status != 2'b01) || (fix_addr != err_byte)) |-> (fix_dout == fix_din));

    p_one_bit_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((status == 2'b01) && (fix_addr == err_byte)) |-> ($countones(fix_dout ^ fix_din) == 1));
endmodule

bind ham_sector_chk ham_sector_chk_sva u_sva (
    .clk(clk), .rst_n(rst_n), .start(start), .acc_word(acc_word),
    .ecc_b0(ecc_b0), .ecc_b1(ecc_b1), .ecc_b2(ecc_b2),
    .fix_addr(fix_addr), .fix_din(fix_din), .done(done), .status(status),
    .err_byte(err_byte), .err_bit(err_bit), .fix_dout(fix_dout)
);

// File: tb/sim_ham_sector_chk.sv
module sim_ham_sector_chk;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] acc_word = '0;
    logic [7:0]  ecc_b0 = '0, ecc_b1 = '0, ecc_b2 = '0;
    logic [8:0]  fix_addr = '0;
    logic [7:0]  fix_din = '0;
    logic        done, done1;
    logic [1:0]  status, status1;
    logic [8:0]  err_byte, err_byte1;
    logic [2:0]  err_bit, err_bit1;
    logic [7:0]  fix_dout, fix_dout1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ham_sector_chk u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .acc_word(acc_word),
        .ecc_b0(ecc_b0), .ecc_b1(ecc_b1), .ecc_b2(ecc_b2),
        .fix_addr(fix_addr), .fix_din(fix_din), .done(done), .status(status),
        .err_byte(err_byte), .err_bit(err_bit), .fix_dout(fix_dout)
    );

    // Smaller sector to reach the range rejection.
    ham_sector_chk #(.SECTOR_BYTES(300)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start), .acc_word(acc_word),
        .ecc_b0(ecc_b0), .ecc_b1(ecc_b1), .ecc_b2(ecc_b2),
        .fix_addr(fix_addr), .fix_din(fix_din), .done(done1), .status(status1),
        .err_byte(err_byte1), .err_bit(err_bit1), .fix_dout(fix_dout1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Accumulator word whose rebuilt code is c, with junk in ignored bits.
    function automatic logic [31:0] acc_for(input logic [23:0] c);
        logic [23:0] n;
        n = ~c;
        return {4'hA, n[23:12], 4'h5, n[11:0]};
    endfunction

    // Difference pattern for a data-bit error at byte b, bit k.
    function automatic logic [23:0] data_diff(input logic [8:0] b, input logic [2:0] k);
        logic [11:0] hi;
        hi = {b, k};
        return {hi, ~hi};
    endfunction

    // Present inputs, strobe start, leave outputs sampled after the result edge.
    task automatic run(input logic [31:0] acc, input logic [23:0] stored);
        @(negedge clk);
        acc_word = acc;
        {ecc_b2, ecc_b1, ecc_b0} = stored;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 done", done, 0);
        check("R9 status", status, 2'b00);
        check("R9 location", {err_byte, err_bit}, 0);
    endtask

    task automatic t_erased();
        run(32'h0, 24'hFFFFFF);
        check("R1 done pulse", done, 1);
        check("R3 erased clean", status, 2'b00);
        @(negedge clk);
        check("R1 done one cycle", done, 0);
        check("R1 status held", status, 2'b00);
    endtask

    task automatic t_match();
        logic [23:0] c = 24'h3C5A96;
        run(acc_for(c), c);
        check("R2 match with junk bits clean", status, 2'b00);
        check("R3 location zero", {err_byte, err_bit}, 0);
    endtask

    task automatic t_data_fix(input logic [8:0] b, input logic [2:0] k);
        logic [23:0] c = 24'h81F00D;
        run(acc_for(c), c ^ data_diff(b, k));
        check("R4 status", status, 2'b01);
        check("R4 byte", err_byte, b);
        check("R4 bit", err_bit, k);
        fix_addr = b; fix_din = 8'h5A;
        #1 check("R8 fixed byte", fix_dout, 8'h5A ^ (8'h1 << k));
        fix_addr = b ^ 9'h1;
        #1 check("R8 other byte untouched", fix_dout, 8'h5A);
    endtask

    task automatic t_range();
        logic [23:0] c = 24'h123456;
        run(acc_for(c), c ^ data_diff(9'd400, 3'd6));
        check("R5 small sector rejects 400", status1, 2'b11);
        check("R5 location zero", {err_byte1, err_bit1}, 0);
        check("R4 full sector accepts 400", status, 2'b01);
        run(acc_for(c), c ^ data_diff(9'd299, 3'd1));
        check("R5 last byte in range", status1, 2'b01);
        check("R5 last byte index", err_byte1, 9'd299);
    endtask

    task automatic t_code_only();
        logic [23:0] c = 24'h0F0F0F;
        for (int i = 0; i < 24; i += 11) begin
            run(acc_for(c), c ^ (24'h1 << i));
            check("R6 code-only status", status, 2'b10);
            check("R6 location zero", {err_byte, err_bit}, 0);
            fix_addr = 9'd0; fix_din = 8'hC3;
            #1 check("R6 no repair", fix_dout, 8'hC3);
        end
    endtask

    task automatic t_fatal();
        logic [23:0] c = 24'h777777;
        run(acc_for(c), c ^ 24'h000011);
        check("R7 two-bit fatal", status, 2'b11);
        run(acc_for(c), c ^ 24'h800001);
        check("R7 far two-bit fatal", status, 2'b11);
        check("R7 location zero", {err_byte, err_bit}, 0);
    endtask

    task automatic t_back_to_back();
        logic [23:0] c = 24'hABCDEF;
        @(negedge clk);
        acc_word = acc_for(c); {ecc_b2, ecc_b1, ecc_b0} = c ^ 24'h000004; start = 1'b1;
        @(negedge clk);
        check("R1 first done", done, 1);
        check("R6 first result", status, 2'b10);
        {ecc_b2, ecc_b1, ecc_b0} = c;
        @(negedge clk);
        start = 1'b0;
        check("R1 second done", done, 1);
        check("R3 second result", status, 2'b00);
        @(negedge clk);
        check("R1 done drops", done, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 2 + 2);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_erased();
        t_match();
        t_data_fix(9'd0, 3'd0);
        t_data_fix(9'd511, 3'd7);
        t_data_fix(9'd137, 3'd3);
        t_range();
        t_code_only();
        t_fatal();
        t_back_to_back();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule